// File: doc/BRIEF.md
# Segmented Address Byte-Lane Bus Unit

This unit sits between an execution core and a 16-bit synchronous memory. It turns a request into one or two memory cycles. A request carries a 16-bit segment, a 16-bit offset, a direction, a size (byte or word) and write data. The unit forms a 20-bit byte address from the segment and the offset. It then places the data on the lane that the low address bit selects.

The memory is two bytes wide. The low lane holds even bytes and the high lane holds odd bytes. A word at an even address uses both lanes in one cycle. A word at an odd address straddles two memory words, so the unit splits it into two byte cycles. The low byte always goes first. Reads return their data in the cycle that `done` is high. A read byte comes back zero-extended in bits 7..0.

The memory port is synchronous. A read returns its data on `mem_rdata` in the clock after the cycle in which `mem_en` was high.

Top module: `segbus_unit`

## Requirements
- R1: The byte address of the first memory cycle is (segment × 16 + offset) mod 2^20. For example, segment 0x0400 with offset 0x0056 gives 0x04056.
- R2: A byte request at an even address makes one cycle with `mem_be` = 2'b01. The write byte goes on `mem_wdata[7:0]`. The read result is `mem_rdata[7:0]`, zero-extended.
- R3: A byte request at an odd address makes one cycle with `mem_be` = 2'b10. The write byte goes on `mem_wdata[15:8]`. The read result is `mem_rdata[15:8]`, zero-extended.
- R4: A word request at an even address makes one cycle with `mem_be` = 2'b11. The low byte is on bits 7..0 and the high byte is on bits 15..8.
- R5: A word request at an odd address A makes two back-to-back cycles. The first is at A with `mem_be` = 2'b10 and carries the low byte on bits 15..8. The second is at A+1 with `mem_be` = 2'b01 and carries the high byte on bits 7..0. A read assembles the word as {second byte, first byte}.
- R6: The address A+1 of the second cycle wraps within 20 bits, so 0xFFFFF is followed by 0x00000.
- R7: `done` is high for exactly one clock: the clock right after the last memory cycle. `rd_data` is valid in that clock.
- R8: A request is accepted only when `req_ready` is high, which is only while the unit is idle. A request presented while the unit is busy causes no memory cycle.
- R9: After reset, `req_ready` is 1 and both `mem_en` and `done` are 0.
- R10: `mem_we` equals the request direction in every cycle of a transfer. The first memory cycle starts in the clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write data; a byte uses bits 7..0 |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid while done |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 20 | Byte address of the cycle |
| mem_be | output | 2 | Lane enables: bit 0 low lane, bit 1 high lane |
| mem_wdata | output | 16 | Lane-steered write data |
| mem_rdata | input | 16 | Read data, one clock after the enable |

## Verification
The unit latches the request at acceptance. A corrupted latched address or size therefore appears on `mem_addr` or `mem_be` in the very next clock. The bench compares both against the arithmetic sum and the lane rule.

A wrong sequencer state shows up as a missing or extra enable cycle, or as `done` arriving one clock early or late. It is caught by counting cycles from acceptance.

A wrong captured byte from a split read appears only in `rd_data` while `done` is high. The bench checks it against its own byte model of memory, sweeping even and odd offsets near the top of the 20-bit space.

// File: rtl/segbus_pkg.sv
package segbus_pkg;

    localparam int SEG_W   = 16;
    localparam int OFF_W   = 16;
    localparam int SHIFT   = 4;
    localparam int PA_W    = 20;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 2;
    localparam int DATA_W  = BYTE_W * LANES;

    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [DATA_W-1:0] dword_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [LANES-1:0]  lane_en_t;

    // Shape of a transfer, decided by size and low address bit
    typedef enum logic [1:0] {
        KIND_BYTE_LO    = 2'd0,
        KIND_BYTE_HI    = 2'd1,
        KIND_WORD_AL    = 2'd2,
        KIND_WORD_SPLIT = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_LAST   = 2'd3
    } state_t;

    typedef struct packed {
        logic   write;
        logic   word;
        paddr_t addr;
        dword_t wdata;
    } xfer_t;

    function automatic kind_t kind_of(input logic word, input logic a0);
        if (word) return a0 ? KIND_WORD_SPLIT : KIND_WORD_AL;
        return a0 ? KIND_BYTE_HI : KIND_BYTE_LO;
    endfunction

endpackage

// File: rtl/segbus_addr_gen.sv
module segbus_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  paddr
);
    localparam int SUM_W = PA_W + 1;

    logic [PA_W-1:0]  seg_base;
    logic [SUM_W-1:0] sum;

    assign seg_base = PA_W'({seg, {SHIFT{1'b0}}});
    assign sum      = {1'b0, seg_base} + SUM_W'(off);
    // carry out of the top bit is dropped: address wraps
    assign paddr    = sum[PA_W-1:0];

    always_comb begin
        // R1
        low_bits_pass_chk: assert (paddr[SHIFT-1:0] == off[SHIFT-1:0]);
    end

endmodule

// File: rtl/segbus_lane_steer.sv
module segbus_lane_steer
    import segbus_pkg::*;
(
    input  kind_t    kind,
    input  logic     second,
    input  dword_t   wdata,
    input  dword_t   rdata,
    input  byte_t    held_lo,
    output lane_en_t be,
    output dword_t   lane_wdata,
    output dword_t   rd_word
);
    always_comb begin
        be         = '0;
        lane_wdata = '0;
        rd_word    = '0;
        case (kind)
            KIND_BYTE_LO: begin
                be         = 2'b01;
                lane_wdata = {{BYTE_W{1'b0}}, wdata[BYTE_W-1:0]};
                rd_word    = {{BYTE_W{1'b0}}, rdata[BYTE_W-1:0]};
            end
            KIND_BYTE_HI: begin
                be         = 2'b10;
                lane_wdata = {wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
                rd_word    = {{BYTE_W{1'b0}}, rdata[DATA_W-1:BYTE_W]};
            end
            KIND_WORD_AL: begin
                be         = 2'b11;
                lane_wdata = wdata;
                rd_word    = rdata;
            end
            default: begin
                if (second) begin
                    be         = 2'b01;
                    lane_wdata = {{BYTE_W{1'b0}}, wdata[DATA_W-1:BYTE_W]};
                end else begin
                    be         = 2'b10;
                    lane_wdata = {wdata[BYTE_W-1:0], {BYTE_W{1'b0}}};
                end
                rd_word = {rdata[BYTE_W-1:0], held_lo};
            end
        endcase
    end

    always_comb begin
        // R2
        lane_enable_nonzero_chk: assert (be != '0);
    end

endmodule

// File: rtl/segbus_seq.sv
module segbus_seq
    import segbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   req_word,
    input  paddr_t req_paddr,
    input  dword_t req_wdata,
    input  byte_t  rdata_hi,
    output logic   ready,
    output logic   issue,
    output logic   second,
    output logic   done,
    output logic   we,
    output paddr_t addr,
    output kind_t  kind,
    output dword_t wdata,
    output byte_t  held_lo
);
    state_t state, state_nx;
    xfer_t  cur;

    assign kind = kind_of(cur.word, cur.addr[0]);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
            ST_FIRST:  state_nx = (kind == KIND_WORD_SPLIT) ? ST_SECOND : ST_LAST;
            ST_SECOND: state_nx = ST_LAST;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            held_lo <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                cur.write <= req_write;
                cur.word  <= req_word;
                cur.addr  <= req_paddr;
                cur.wdata <= req_wdata;
            end
            if (state == ST_SECOND) held_lo <= rdata_hi;
        end
    end

    assign ready  = (state == ST_IDLE);
    assign issue  = (state == ST_FIRST) || (state == ST_SECOND);
    assign second = (state == ST_SECOND);
    assign done   = (state == ST_LAST);
    assign we     = issue && cur.write;
    assign addr   = second ? cur.addr + 1'b1 : cur.addr;
    assign wdata  = cur.wdata;

    // R7
    done_follows_issue_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(issue));
    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    accept_starts_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> (issue && !ready));
    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        issue |-> !ready);

endmodule

// File: rtl/segbus_unit.sv
module segbus_unit
    import segbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_word,
    input  logic [15:0] req_seg,
    input  logic [15:0] req_off,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mem_en,
    output logic        mem_we,
    output logic [19:0] mem_addr,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata
);
    paddr_t   req_paddr;
    logic     issue, second, we_int;
    paddr_t   cyc_addr;
    kind_t    kind;
    dword_t   cur_wdata, lane_wdata, rd_word;
    byte_t    held_lo;
    lane_en_t be;

    segbus_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_addr (
        .seg   (req_seg),
        .off   (req_off),
        .paddr (req_paddr)
    );

    segbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_paddr (req_paddr),
        .req_wdata (req_wdata),
        .rdata_hi  (mem_rdata[DATA_W-1:BYTE_W]),
        .ready     (req_ready),
        .issue     (issue),
        .second    (second),
        .done      (done),
        .we        (we_int),
        .addr      (cyc_addr),
        .kind      (kind),
        .wdata     (cur_wdata),
        .held_lo   (held_lo)
    );

    segbus_lane_steer u_steer (
        .kind       (kind),
        .second     (second),
        .wdata      (cur_wdata),
        .rdata      (mem_rdata),
        .held_lo    (held_lo),
        .be         (be),
        .lane_wdata (lane_wdata),
        .rd_word    (rd_word)
    );

    assign mem_en    = issue;
    assign mem_we    = we_int;
    assign mem_addr  = cyc_addr;
    assign mem_be    = issue ? be : '0;
    assign mem_wdata = we_int ? lane_wdata : '0;
    assign rd_data   = done ? rd_word : '0;

    // R6
    split_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));
    // R5
    split_lane_order_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> (mem_be == 2'b01 && $past(mem_be) == 2'b10));
    // R10
    dir_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && $past(mem_en)) |-> $stable(mem_we));
    // R5
    split_first_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !$past(mem_en) && mem_be == 2'b10) |-> mem_addr[0]);

endmodule

// File: tb/segbus_unit_bench.sv
`timescale 1ns/1ps
module segbus_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic        mem_en, mem_we;
    logic [19:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] mem [256];
    logic [7:0]  refb [512];

    always #2 clk = ~clk;

    segbus_unit u_segbus_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_word(req_word),
        .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // memory model: word index from address bits 8..1
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem[mem_addr[8:1]];
            if (mem_we && mem_be[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            if (mem_we && mem_be[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic wr, input logic wd, input logic [15:0] seg,
                       input logic [15:0] off, input logic [15:0] wdat, input bit hold);
        logic [19:0] ra [2];
        logic [1:0]  rb [2];
        logic [15:0] rw [2];
        logic        rwe [2];
        int          n = 0;
        int          cyc = 0;
        logic [15:0] got = '0;
        bit          seen_done = 0;
        logic [19:0] pa, pa1;
        logic [15:0] exp_rd;
        bit          split;
        logic [1:0]  exp_be;
        pa    = 20'({seg, 4'h0} + {4'h0, off});
        pa1   = pa + 20'd1;
        split = wd && pa[0];
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_word = wd;
        req_seg = seg; req_off = off; req_wdata = wdat;
        @(negedge clk);
        if (hold) begin
            req_off = ~off; req_seg = seg ^ 16'h0101; req_write = ~wr;
        end else req_valid = 1'b0;
        while (cyc < 10 && !seen_done) begin
            cyc++;
            if (mem_en) begin
                if (n < 2) begin
                    ra[n] = mem_addr; rb[n] = mem_be; rw[n] = mem_wdata; rwe[n] = mem_we;
                end
                n++;
            end
            if (done) begin seen_done = 1; got = rd_data; end
            else @(negedge clk);
        end
        req_valid = 1'b0;
        check(seen_done, "R7 watchdog: done seen", 32'(seen_done), 32'd1);
        check(cyc == (split ? 3 : 2), "R7 done timing", 32'(cyc), split ? 32'd3 : 32'd2);
        check(n == (split ? 2 : 1), "R8 cycle count", 32'(n), split ? 32'd2 : 32'd1);
        if (n >= 1) begin
            check(ra[0] == pa, "R1 first address", 32'(ra[0]), 32'(pa));
            check(rwe[0] == wr, "R10 direction", 32'(rwe[0]), 32'(wr));
            if (!wd) exp_be = pa[0] ? 2'b10 : 2'b01;
            else     exp_be = pa[0] ? 2'b10 : 2'b11;
            check(rb[0] == exp_be, wd ? (pa[0] ? "R5 first lanes" : "R4 lanes")
                                      : (pa[0] ? "R3 lanes" : "R2 lanes"), 32'(rb[0]), 32'(exp_be));
            if (wr) begin
                if (!wd && !pa[0]) check(rw[0][7:0] == wdat[7:0], "R2 write lane", 32'(rw[0]), 32'(wdat[7:0]));
                if (!wd && pa[0])  check(rw[0][15:8] == wdat[7:0], "R3 write lane", 32'(rw[0]), 32'(wdat[7:0]));
                if (wd && !pa[0])  check(rw[0] == wdat, "R4 write word", 32'(rw[0]), 32'(wdat));
                if (split)         check(rw[0][15:8] == wdat[7:0], "R5 first byte", 32'(rw[0]), 32'(wdat[7:0]));
            end
        end
        if (split && n >= 2) begin
            check(ra[1] == pa1, "R6 second address", 32'(ra[1]), 32'(pa1));
            check(rb[1] == 2'b01, "R5 second lanes", 32'(rb[1]), 32'd1);
            check(rwe[1] == wr, "R10 direction second", 32'(rwe[1]), 32'(wr));
            if (wr) check(rw[1][7:0] == wdat[15:8], "R5 second byte", 32'(rw[1]), 32'(wdat[15:8]));
        end
        if (!wr) begin
            exp_rd = wd ? {refb[pa1[8:0]], refb[pa[8:0]]} : {8'h00, refb[pa[8:0]]};
            check(got == exp_rd, wd ? (split ? "R5 read word" : "R4 read word")
                                    : (pa[0] ? "R3 read byte" : "R2 read byte"), 32'(got), 32'(exp_rd));
        end else begin
            refb[pa[8:0]] = wdat[7:0];
            if (wd) refb[pa1[8:0]] = wdat[15:8];
        end
        @(negedge clk);
        check(done == 1'b0, "R7 done one clock", 32'(done), 32'd0);
        check(mem_en == 1'b0 && req_ready == 1'b1, "R8 idle after done",
              32'({mem_en, req_ready}), 32'd1);
    endtask

    initial begin
        repeat (800000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] segs [5];
        logic [15:0] base;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'(i * 16'h0107 + 16'h3c5a);
            refb[2*i]   = mem[i][7:0];
            refb[2*i+1] = mem[i][15:8];
        end
        segs[0] = 16'h0000; segs[1] = 16'h0400; segs[2] = 16'h1234;
        segs[3] = 16'hFFFF; segs[4] = 16'hF000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        check(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
        check(mem_en == 1'b0, "R9 no enable in reset", 32'(mem_en), 32'd0);
        check(done == 1'b0, "R9 no done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        // R1 worked example: read at 0x04056
        run(1'b0, 1'b1, 16'h0400, 16'h0056, 16'h0000, 1'b0);
        for (int s = 0; s < 5; s++) begin
            base = (s == 3) ? 16'h0000 : ((s == 4) ? 16'hFFF0 : 16'h0050);
            for (int k = 0; k < 16; k++) begin
                logic [15:0] off;
                logic [15:0] pat;
                off = base + 16'(k);
                pat = 16'(k * 16'h1111) ^ segs[s];
                run(1'b1, 1'b1, segs[s], off, pat, 1'b0);
                run(1'b0, 1'b1, segs[s], off, 16'h0, 1'b0);
                run(1'b0, 1'b0, segs[s], off, 16'h0, 1'b0);
                run(1'b1, 1'b0, segs[s], off, ~pat, 1'b0);
                run(1'b0, 1'b1, segs[s], off, 16'h0, 1'b0);
            end
        end
        // R8 requests held while busy are ignored
        run(1'b1, 1'b1, 16'h0010, 16'h0031, 16'hBEEF, 1'b1);
        run(1'b0, 1'b1, 16'h0010, 16'h0031, 16'h0000, 1'b1);
        run(1'b0, 1'b0, 16'h0010, 16'h0032, 16'h0000, 1'b1);
        // R6 wrap at the top of the space
        run(1'b1, 1'b1, 16'hFFFF, 16'h000F, 16'hA55A, 1'b0);
        run(1'b0, 1'b1, 16'hF000, 16'hFFFF, 16'h0000, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule